// File: doc/BRIEF.md
# Bidirectional Dual-Bus Shift Register

This block holds an eight-stage word between two 8-bit tri-state buses, called A and B. It can take a whole word from one bus and present it on the other, or build a word one bit at a time from a serial input on the clock. A direction control picks the source and destination buses. A mode control picks parallel or serial entry. A capture control picks between an edge-clocked parallel load and a transparent parallel transfer that does not wait for the clock. A further control takes bus A out of any transfer.

The pads are outside the block. It supplies the data to drive on each bus and a drive enable for each bus, and it reads both buses through plain inputs. The source bus is never driven. In transparent mode the destination bus follows the source bus in the same cycle. The stored word takes the source value on each rising edge, so after the transparent phase ends the register holds the value captured at the last edge.

Top module: `duplex_shift_reg`

## Requirements
- R1: When `rst_n` is low at a rising edge, all eight stages become 0.
- R2: With `par_mode` low, each rising edge moves every stage k to stage k+1 (bit k to bit k+1) and loads `ser_in` into stage 1, which is bit 0. The old bit 7 is lost.
- R3: With `par_mode` high, `async_cap` low, `dir_a2b` high and `a_en` high, a rising edge loads `a_in` into the register. Before that edge, B carries the old word.
- R4: With `par_mode` high, `async_cap` low and `dir_a2b` low, a rising edge loads `b_in` into the register, whatever the level of `a_en`.
- R5: With `par_mode` high and `async_cap` high, the destination output equals the source bus in the same cycle without a clock edge, and each rising edge stores that source value.
- R6: With `a_en` low and `dir_a2b` high, a parallel load leaves the stored word unchanged and the outputs show the stored word. This holds in both clocked and transparent capture.
- R7: `b_oe` equals `dir_a2b`. `a_oe` is high only when `dir_a2b` is low and `a_en` is high. The two are never high together.
- R8: `a_out` and `b_out` both carry the visible word. In transparent capture with an enabled source, that word is the source bus. Otherwise it is the stored word.
- R9: Serial shifting does not depend on `dir_a2b` or `a_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear |
| a_en | input | 1 | Allows bus A to take part in transfers |
| dir_a2b | input | 1 | 1: A is the source and B the destination; 0: B is the source and A the destination |
| par_mode | input | 1 | 1: parallel word entry; 0: serial entry |
| async_cap | input | 1 | 1: transparent parallel transfer; 0: edge-clocked load |
| ser_in | input | 1 | Serial data into stage 1 |
| a_in | input | 8 | Value read from bus A |
| b_in | input | 8 | Value read from bus B |
| a_out | output | 8 | Data to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | 8 | Data to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
A wrong stored stage shows up at the outputs no later than the next cycle in which the register is not transparent, because both output words carry the stored value directly. A fault in the shift path moves one bit out of place on every later edge, so a wrong bit spreads toward stage 8 and stays visible for up to eight edges. The bench compares every cycle against a behavioural model. This covers transparent phases where the outputs follow the buses while the stored word changes unseen, and that stored word is checked in the first cycle after the phase ends.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int DSR_W = 8;

    typedef enum logic {
        SRC_BUS_B = 1'b0,
        SRC_BUS_A = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic [DSR_W-1:0] cells;
    } chain_state_t;
endpackage

// File: rtl/dsr_xfer_ctrl.sv
module dsr_xfer_ctrl
    import dsr_pkg::*;
(
    input  logic     a_en,
    input  logic     dir_a2b,
    input  logic     par_mode,
    input  logic     async_cap,
    output src_sel_e src_sel,
    output logic     load_en,
    output logic     shift_en,
    output logic     transp,
    output logic     a_oe,
    output logic     b_oe
);
    logic src_ok;

    always_comb begin
        src_sel  = dir_a2b ? SRC_BUS_A : SRC_BUS_B;
        src_ok   = (src_sel == SRC_BUS_B) || a_en;
        load_en  = par_mode && src_ok;
        shift_en = !par_mode;
        transp   = par_mode && async_cap && src_ok;
        b_oe     = (src_sel == SRC_BUS_A);
        a_oe     = (src_sel == SRC_BUS_B) && a_en;
    end

    always_comb begin
        assert_one_driver_R7: assert (!(a_oe && b_oe));
        assert_mode_excl_R2: assert (!(load_en && shift_en));
    end
endmodule

// File: rtl/dsr_stage_chain.sv
module dsr_stage_chain
    import dsr_pkg::*;
#(
    parameter int W = DSR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         shift_en,
    input  logic         ser_in,
    input  logic [W-1:0] src_word,
    output logic [W-1:0] q
);
    chain_state_t st_d, st_q;
    logic [W-1:0] cell_d;

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i == 0) begin : g_first
            always_comb begin
                if (load_en)       cell_d[i] = src_word[i];
                else if (shift_en) cell_d[i] = ser_in;
                else               cell_d[i] = st_q.cells[i];
            end
        end else begin : g_rest
            always_comb begin
                if (load_en)       cell_d[i] = src_word[i];
                else if (shift_en) cell_d[i] = st_q.cells[i-1];
                else               cell_d[i] = st_q.cells[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.cells = rst_n ? cell_d : '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.cells;

    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            assert_reset_clear_R1: assert (q == '0);
        end
    end

    assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (q[W-1:1] == $past(q[W-2:0])) && (q[0] == $past(ser_in)));

    assert_par_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> q == $past(src_word));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> $stable(q));
endmodule

// File: rtl/dsr_bus_drive.sv
module dsr_bus_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] stored,
    input  logic [W-1:0] src_word,
    input  logic         transp,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out
);
    logic [W-1:0] vis_word;

    always_comb begin
        vis_word = transp ? src_word : stored;
        a_out    = vis_word;
        b_out    = vis_word;
    end
endmodule

// File: rtl/duplex_shift_reg.sv
module duplex_shift_reg
    import dsr_pkg::*;
#(
    parameter int W = DSR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_en,
    input  logic         dir_a2b,
    input  logic         par_mode,
    input  logic         async_cap,
    input  logic         ser_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    src_sel_e     src_sel;
    logic         load_en, shift_en, transp;
    logic [W-1:0] src_word;
    logic [W-1:0] q_w;

    dsr_xfer_ctrl u_ctrl (
        .a_en     (a_en),
        .dir_a2b  (dir_a2b),
        .par_mode (par_mode),
        .async_cap(async_cap),
        .src_sel  (src_sel),
        .load_en  (load_en),
        .shift_en (shift_en),
        .transp   (transp),
        .a_oe     (a_oe),
        .b_oe     (b_oe)
    );

    assign src_word = (src_sel == SRC_BUS_A) ? a_in : b_in;

    dsr_stage_chain #(.W(W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .shift_en(shift_en),
        .ser_in  (ser_in),
        .src_word(src_word),
        .q       (q_w)
    );

    dsr_bus_drive #(.W(W)) u_drive (
        .stored  (q_w),
        .src_word(src_word),
        .transp  (transp),
        .a_out   (a_out),
        .b_out   (b_out)
    );

    assert_transp_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        transp |=> q_w == $past(b_out));

    assert_dest_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_a2b |-> !a_oe);
endmodule

// File: tb/sim_duplex_shift_reg.sv
`timescale 1ns/1ps
module sim_duplex_shift_reg;
    logic       clk = 1'b0;
    logic       rst_n, a_en, dir_a2b, par_mode, async_cap, ser_in;
    logic [7:0] a_in, b_in, a_out, b_out;
    logic       a_oe, b_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] model;

    always #2.5 clk = ~clk;

    duplex_shift_reg u0 (
        .clk(clk), .rst_n(rst_n), .a_en(a_en), .dir_a2b(dir_a2b),
        .par_mode(par_mode), .async_cap(async_cap), .ser_in(ser_in),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) model <= 8'h00;
        else if (par_mode) begin
            if (dir_a2b && a_en) model <= a_in;
            else if (!dir_a2b)   model <= b_in;
        end else model <= {model[6:0], ser_in};
    end

    task automatic check(input string tag);
        logic [7:0] ev;
        logic ea, eb;
        logic live;
        live = par_mode && async_cap && (!dir_a2b || a_en);
        ev = live ? (dir_a2b ? a_in : b_in) : model;
        eb = dir_a2b;
        ea = !dir_a2b && a_en;
        checks++;
        if (a_out !== ev || b_out !== ev || a_oe !== ea || b_oe !== eb) begin
            failures++;
            $display("FAIL %s: a_out=%h b_out=%h a_oe=%b b_oe=%b expected out=%h a_oe=%b b_oe=%b",
                     tag, a_out, b_out, a_oe, b_oe, ev, ea, eb);
        end
    endtask

    task automatic cyc(input logic r, input logic ae, input logic d, input logic p,
                       input logic asy, input logic s, input logic [7:0] av,
                       input logic [7:0] bv, input string tag);
        @(negedge clk);
        rst_n = r; a_en = ae; dir_a2b = d; par_mode = p; async_cap = asy;
        ser_in = s; a_in = av; b_in = bv;
        #0.5;
        check(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model = 8'h00;
        rst_n = 0; a_en = 0; dir_a2b = 0; par_mode = 0; async_cap = 0;
        ser_in = 0; a_in = 0; b_in = 0;
        @(negedge clk); @(negedge clk);
        model = 8'h00;
        // R1: reset clears
        cyc(0, 1, 1, 0, 0, 1, 8'h00, 8'h00, "R1 reset");
        cyc(0, 1, 1, 0, 0, 1, 8'h00, 8'h00, "R1 reset");
        // R2 and R9: serial in various directions and enables
        for (int i = 0; i < 10; i++)
            cyc(1, i[0], i[1], 0, 0, (8'hB5 >> (i % 8)) & 1'b1, 8'hFF, 8'h00, "R2 R9 serial");
        // R3: clocked A to B
        cyc(1, 1, 1, 1, 0, 0, 8'h3C, 8'h00, "R3 load A");
        cyc(1, 1, 1, 1, 0, 0, 8'hA7, 8'h11, "R3 load A");
        cyc(1, 1, 1, 0, 0, 0, 8'hFF, 8'hFF, "R3 R7 hold view");
        // R4: clocked B to A, a_en both levels
        cyc(1, 1, 0, 1, 0, 0, 8'h00, 8'h5A, "R4 load B");
        cyc(1, 0, 0, 1, 0, 0, 8'h00, 8'hC3, "R4 R7 load B a_en low");
        cyc(1, 1, 0, 0, 0, 1, 8'h00, 8'h00, "R4 after");
        // R6: a_en low blocks A source, clocked and transparent
        cyc(1, 0, 1, 1, 0, 0, 8'h99, 8'h00, "R6 blocked clocked");
        cyc(1, 0, 1, 1, 1, 0, 8'h66, 8'h00, "R6 blocked transparent");
        cyc(1, 0, 1, 1, 1, 0, 8'h12, 8'h00, "R6 blocked transparent");
        // R5 and R8: transparent follows source without clock
        cyc(1, 1, 1, 1, 1, 0, 8'h81, 8'h00, "R5 R8 transp A");
        #0.5 a_in = 8'h7E; #0.5 check("R5 mid-cycle follow A");
        cyc(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R5 stored after A");
        cyc(1, 1, 0, 1, 1, 0, 8'h00, 8'h42, "R5 transp B");
        #0.5 b_in = 8'hE1; #0.5 check("R5 mid-cycle follow B");
        cyc(1, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R5 stored after B");
        // mixed sweep
        for (int i = 0; i < 24; i++)
            cyc(1, i[1], i[2], i[0], i[3], i[4], 8'(i * 37 + 5), 8'(i * 91 + 3), "R2 R3 R4 R5 R6 R8 sweep");
        cyc(0, 1, 0, 1, 0, 0, 8'hFF, 8'hFF, "R1 reset again");
        cyc(1, 1, 0, 0, 0, 0, 8'hFF, 8'hFF, "R1 cleared");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule